// File: doc/BRIEF.md
# Sample Rate to Log-Pitch Converter

This block turns an unsigned 32-bit sampling rate into a 32-bit fixed-point base-2 logarithmic pitch word for a wavetable voice engine. It first multiplies the rate by a fixed scale constant. It then finds the most significant set bit of the product and shifts the product left so that bit becomes bit 31. The result is the sum of three terms:
- a signed integer exponent placed at bit 20;
- a mantissa magnitude read from a 128-entry table;
- a linear correction, equal to a 7-bit fraction times an entry of a 128-entry slope table.

Both tables are computed from a base-2 logarithm formula when the design is elaborated, so no table contents are written into the source.

Rates arrive on a valid/ready handshake. The unit is a fixed three-stage pipeline (scale, normalise, look up and add) that can take a new rate on every cycle. Each accepted rate produces one result, marked by a valid pulse, in the same order the rates were accepted. A zero rate gives a zero pitch. A scaled product whose only set bit is bit 0 cannot be normalised, so it gives a zero pitch together with an error flag.

Top module: `rate_pitch_conv`

## Requirements
- R1: While `rst` is high, `inReady` and `outValid` are 0. `inReady` is 1 from the first clock edge after `rst` falls, and stays 1 from then on.
- R2: A rate is accepted on a rising edge at which `inValid` and `inReady` are both 1. Its result, with `outValid` at 1, is visible after the third rising edge, counting the accept edge as the first. Results come out in acceptance order, one per accepted rate.
- R3: A rate of 0 gives `pitchOut` = 0 with `pitchErr` = 0.
- R4: The scaled value is (rate × 11185) mod 2^32. If its highest set bit is at position p, with p ≥ 1, the exponent term is ((p − 15) << 20), taken modulo 2^32 (two's complement).
- R5: The scaled value shifted left by (31 − p) is the normalised word. Its bits [30:24] are the table index k, and its bits [23:17] are the fraction f. The result `pitchOut` = exponent term + M[k] + f × S[k], modulo 2^32.
- R6: M[k] is the 20-bit base-2 logarithm fraction of (128 + k)/128. It is found by 20 steps, starting from y = (128 + k)·2^23 with 2^30 standing for 1.0. Each step, from bit 19 down to bit 0, first sets y = floor(y²/2^30). If y ≥ 2^31, that step's bit is 1 and y is halved; otherwise the bit is 0. S[k] = (M[k+1] − M[k] + 64) >> 7, with M[128] taken as 2^20.
- R7: A scaled value equal to 1 (leading one at bit 0) gives `pitchOut` = 0 with `pitchErr` = 1.
- R8: `pitchErr` is 0 for every result except the case in R7, and is never 1 while `outValid` is 0.
- R9: A cycle with `inValid` low starts no result: `outValid` stays 0 on the cycle where such a rate would have appeared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Rate on `rateIn` is offered |
| inReady | output | 1 | Converter can take a rate this cycle |
| rateIn | input | 32 | Unsigned sampling rate |
| outValid | output | 1 | `pitchOut` and `pitchErr` carry a result |
| pitchOut | output | 32 | Log-domain pitch word |
| pitchErr | output | 1 | Rate could not be normalised |

## Verification
Every result is due exactly after the third rising edge, counting the edge that accepted the rate. No other event moves it earlier or later. The bench drives one rate (or an idle slot) per cycle on the falling edge. At each rising edge it shifts the slot into a three-deep history of its own. On the following falling edge it compares `outValid`, `pitchOut` and `pitchErr` with the entry that has just reached the oldest position of that history. This makes every check land on the cycle the requirement names. The same three-edge distance appears in the clocked properties as `|=> ##2`, and as a `$past` of depth three.

// File: rtl/rate_pitch_pkg.sv
package rate_pitch_pkg;

  localparam int RATE_W  = 32;
  localparam int IDX_W   = 7;
  localparam int FRAC_W  = 7;
  localparam int MAG_W   = 20;
  localparam int SLOPE_W = 8;
  localparam int POS_W   = $clog2(RATE_W);
  localparam int ENTRIES = 1 << IDX_W;

  // Strobes from the control into the datapath stages
  typedef struct packed {
    logic ldScale;
    logic ldNorm;
    logic ldOut;
  } stageStrobe_t;

  // Base-2 log fraction of (ENTRIES + k) / ENTRIES by repeated squaring
  function automatic logic [MAG_W-1:0] magEntry(input int k);
    logic [63:0] y;
    logic [MAG_W-1:0] r;
    y = 64'(ENTRIES + k) << (30 - IDX_W);
    r = '0;
    for (int b = MAG_W - 1; b >= 0; b--) begin
      y = (y * y) >> 30;
      if (y >= 64'h8000_0000) begin
        r[b] = 1'b1;
        y = y >> 1;
      end
    end
    return r;
  endfunction

  // Rounded per-step slope between neighbouring magnitude entries
  function automatic logic [SLOPE_W-1:0] slopeEntry(input int k);
    int cur;
    int nxt;
    cur = int'(magEntry(k));
    nxt = (k == ENTRIES - 1) ? (1 << MAG_W) : int'(magEntry(k + 1));
    return SLOPE_W'((nxt - cur + (1 << (FRAC_W - 1))) >> FRAC_W);
  endfunction

endpackage

// File: rtl/rate_pitch_tables.sv
module rate_pitch_tables
  import rate_pitch_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int MW = MAG_W,
  parameter int SW = SLOPE_W
) (
  input  logic [IW-1:0] idx,
  output logic [MW-1:0] magOut,
  output logic [SW-1:0] slopeOut
);

  localparam int DEPTH = 1 << IW;

  logic [MW-1:0] magRom   [DEPTH];
  logic [SW-1:0] slopeRom [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_rom
    assign magRom[k]   = MW'(magEntry(k));
    assign slopeRom[k] = SW'(slopeEntry(k));
  end

  assign magOut   = magRom[idx];
  assign slopeOut = slopeRom[idx];

endmodule

// File: rtl/rate_pitch_normalise.sv
module rate_pitch_normalise
  import rate_pitch_pkg::*;
#(
  parameter int W  = RATE_W,
  parameter int PW = POS_W,
  parameter int FW = IDX_W + FRAC_W
) (
  input  logic [W-1:0]  scaled,
  output logic [PW-1:0] leadPos,
  output logic [FW-1:0] fields,
  output logic          noLead
);

  localparam int DROP = W - 1 - FW;

  logic [PW-1:0] shiftAmt;
  logic [W-1:0]  normWord;

  // Priority encoder: the highest set bit wins
  always_comb begin
    leadPos = '0;
    for (int b = 0; b < W; b++) begin
      if (scaled[b]) leadPos = PW'(b);
    end
  end

  assign shiftAmt = PW'(W - 1) - leadPos;
  assign normWord = scaled << shiftAmt;
  assign fields   = FW'(normWord >> DROP);
  assign noLead   = (scaled[W-1:1] == '0);

endmodule

// File: rtl/rate_pitch_control.sv
module rate_pitch_control
  import rate_pitch_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output logic         inReady,
  output logic         outValid,
  output stageStrobe_t strobe
);

  logic readyQ;
  logic s1Valid;
  logic s2Valid;
  logic s3Valid;
  logic accept;

  assign accept = inValid && readyQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      readyQ  <= 1'b0;
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
      s3Valid <= 1'b0;
    end else begin
      readyQ  <= 1'b1;
      s1Valid <= accept;
      s2Valid <= s1Valid;
      s3Valid <= s2Valid;
    end
  end

  always_comb begin
    strobe.ldScale = accept;
    strobe.ldNorm  = s1Valid;
    strobe.ldOut   = s2Valid;
  end

  assign inReady  = readyQ;
  assign outValid = s3Valid;

endmodule

// File: rtl/rate_pitch_datapath.sv
module rate_pitch_datapath
  import rate_pitch_pkg::*;
#(
  parameter int W     = RATE_W,
  parameter int SCALE = 11185,
  parameter int BIAS  = 15,
  parameter int EXP_SHIFT = MAG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  stageStrobe_t strobe,
  input  logic [W-1:0] rateIn,
  output logic [W-1:0] pitchOut,
  output logic         pitchErr
);

  localparam int FW = IDX_W + FRAC_W;

  // Stage 1: scaling
  logic [W-1:0] scaledQ;
  logic         zeroQ1;

  // Stage 2: normalisation
  logic [POS_W-1:0] posD;
  logic [FW-1:0]    fieldsD;
  logic             noLeadD;
  logic [POS_W-1:0] posQ;
  logic [FW-1:0]    fieldsQ;
  logic             zeroQ2;
  logic             errQ2;

  // Stage 3: table lookup and sum
  logic [IDX_W-1:0]   tabIdx;
  logic [FRAC_W-1:0]  tabFrac;
  logic [MAG_W-1:0]   magVal;
  logic [SLOPE_W-1:0] slopeVal;
  logic [W-1:0]       expTerm;
  logic [W-1:0]       interpTerm;
  logic [W-1:0]       sumD;
  logic [W-1:0]       pitchQ;
  logic               errQ3;

  always_ff @(posedge clk) begin
    if (rst) begin
      scaledQ <= '0;
      zeroQ1  <= 1'b0;
    end else if (strobe.ldScale) begin
      scaledQ <= rateIn * W'(SCALE);
      zeroQ1  <= (rateIn == '0);
    end
  end

  rate_pitch_normalise #(
    .W (W),
    .PW(POS_W),
    .FW(FW)
  ) norm_i (
    .scaled (scaledQ),
    .leadPos(posD),
    .fields (fieldsD),
    .noLead (noLeadD)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      posQ    <= '0;
      fieldsQ <= '0;
      zeroQ2  <= 1'b0;
      errQ2   <= 1'b0;
    end else if (strobe.ldNorm) begin
      posQ    <= posD;
      fieldsQ <= fieldsD;
      zeroQ2  <= zeroQ1;
      errQ2   <= noLeadD && !zeroQ1;
    end
  end

  assign tabIdx  = fieldsQ[FW-1:FRAC_W];
  assign tabFrac = fieldsQ[FRAC_W-1:0];

  rate_pitch_tables #(
    .IW(IDX_W),
    .MW(MAG_W),
    .SW(SLOPE_W)
  ) tab_i (
    .idx     (tabIdx),
    .magOut  (magVal),
    .slopeOut(slopeVal)
  );

  assign expTerm    = (W'(posQ) - W'(BIAS)) << EXP_SHIFT;
  assign interpTerm = W'(tabFrac) * W'(slopeVal);
  assign sumD       = (zeroQ2 || errQ2) ? '0 : (expTerm + W'(magVal) + interpTerm);

  always_ff @(posedge clk) begin
    if (rst) begin
      pitchQ <= '0;
      errQ3  <= 1'b0;
    end else if (strobe.ldOut) begin
      pitchQ <= sumD;
      errQ3  <= errQ2;
    end
  end

  assign pitchOut = pitchQ;
  assign pitchErr = errQ3;

endmodule

// File: rtl/rate_pitch_conv.sv
module rate_pitch_conv
  import rate_pitch_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [RATE_W-1:0] rateIn,
  output logic              outValid,
  output logic [RATE_W-1:0] pitchOut,
  output logic              pitchErr
);

  stageStrobe_t strobe;
  logic         errRaw;

  rate_pitch_control ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inReady (inReady),
    .outValid(outValid),
    .strobe  (strobe)
  );

  rate_pitch_datapath #(
    .W(RATE_W)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .rateIn  (rateIn),
    .pitchOut(pitchOut),
    .pitchErr(errRaw)
  );

  assign pitchErr = errRaw && outValid;

endmodule

// File: rtl/rate_pitch_conv_chk.sv
module rate_pitch_conv_chk
  import rate_pitch_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inReady,
  input logic [RATE_W-1:0] rateIn,
  input logic              outValid,
  input logic [RATE_W-1:0] pitchOut,
  input logic              pitchErr
);

  p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> inReady);

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> ##2 outValid);

  p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid && inReady, 3));

  p_zero_rate_r3: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && rateIn == '0) |=> ##2 (outValid && pitchOut == '0 && !pitchErr));

  p_err_zero_r7: assert property (@(posedge clk) disable iff (rst)
    pitchErr |-> (pitchOut == '0));

  p_err_valid_r8: assert property (@(posedge clk) disable iff (rst)
    pitchErr |-> outValid);

endmodule

bind rate_pitch_conv rate_pitch_conv_chk chk_i (.*);

// File: tb/rate_pitch_conv_tb_top.sv
module rate_pitch_conv_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic        inReady;
  logic [31:0] rateIn;
  logic        outValid;
  logic [31:0] pitchOut;
  logic        pitchErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int unsigned magT [129];
  int unsigned slopeT [128];

  // three-deep history of offered slots
  bit          hV [3];
  logic [31:0] hR [3];

  always #10 clk = ~clk;

  rate_pitch_conv dut_i (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inReady (inReady),
    .rateIn  (rateIn),
    .outValid(outValid),
    .pitchOut(pitchOut),
    .pitchErr(pitchErr)
  );

  function automatic int unsigned refLog(input int k);
    longint unsigned y;
    int unsigned r;
    y = longint'(128 + k) << 23;
    r = 0;
    for (int b = 19; b >= 0; b--) begin
      y = (y * y) >> 30;
      if (y >= 64'h8000_0000) begin
        r = r | (32'd1 << b);
        y = y >> 1;
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] refPitch(input logic [31:0] r, output bit e);
    logic [31:0] s;
    logic [31:0] n;
    int p;
    int unsigned k;
    int unsigned f;
    e = 1'b0;
    if (r == 0) return 32'd0;
    s = r * 32'd11185;
    p = -1;
    for (int b = 31; b >= 0; b--) if (p < 0 && s[b]) p = b;
    if (p == 0) begin
      e = 1'b1;
      return 32'd0;
    end
    n = s << (31 - p);
    k = 32'(n[30:24]);
    f = 32'(n[23:17]);
    return (32'(p - 15) << 20) + magT[k] + f * slopeT[k];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Offer one slot, advance one edge, then compare the output due now
  task automatic step(input bit v, input logic [31:0] r);
    bit e;
    logic [31:0] p;
    inValid = v;
    rateIn  = r;
    @(posedge clk);
    hV[2] = hV[1]; hR[2] = hR[1];
    hV[1] = hV[0]; hR[1] = hR[0];
    hV[0] = v;     hR[0] = r;
    @(negedge clk);
    check("R2/R9 outValid", 32'(outValid), 32'(hV[2]));
    if (hV[2]) begin
      p = refPitch(hR[2], e);
      if (hR[2] == 0) check("R3 zero rate", pitchOut, 32'd0);
      else if (e)     check("R7 error pitch", pitchOut, 32'd0);
      else            check("R4/R5/R6 pitch", pitchOut, p);
      check(e ? "R7 error flag" : "R8 error flag", 32'(pitchErr), 32'(e));
    end else begin
      check("R8 flag idle", 32'(pitchErr), 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] inv;
    logic [31:0] seedVal;
    for (int k = 0; k < 128; k++) magT[k] = refLog(k);
    magT[128] = 32'h10_0000;
    for (int k = 0; k < 128; k++) slopeT[k] = (magT[k+1] - magT[k] + 64) >> 7;
    // inverse of the scale constant modulo 2^32 gives a scaled value of 1
    inv = 32'd11185;
    for (int i = 0; i < 5; i++) inv = inv * (32'd2 - 32'd11185 * inv);
    for (int i = 0; i < 3; i++) begin hV[i] = 1'b0; hR[i] = '0; end
    seedVal = $urandom(32'd20240611);

    rst = 1'b1; inValid = 1'b0; rateIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 ready in reset", 32'(inReady), 32'd0);
    check("R1 valid in reset", 32'(outValid), 32'd0);
    // rate offered during reset must not be taken
    inValid = 1'b1; rateIn = 32'd8000;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; inValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 ready after reset", 32'(inReady), 32'd1);
    check("R1 valid after reset", 32'(outValid), 32'd0);

    // directed corners
    step(1'b1, 32'd1);
    step(1'b1, 32'd8000);
    step(1'b1, 32'd44100);
    step(1'b1, 32'd48000);
    step(1'b1, 32'hFFFF_FFFF);
    step(1'b1, 32'd0);
    step(1'b1, inv);
    step(1'b0, 32'd12345);
    step(1'b1, 32'd22050);
    step(1'b0, 32'd0);
    step(1'b1, inv);
    step(1'b1, 32'd0);
    step(1'b1, 32'd2);

    // random mix of low rates, wide rates and idle slots
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      bit v;
      v = ($urandom % 4) != 0;
      case ($urandom % 4)
        0: r = $urandom % 48000;
        1: r = $urandom % 256;
        2: r = $urandom;
        default: r = 32'd1 << ($urandom % 32);
      endcase
      step(v, r);
    end
    for (int i = 0; i < 4; i++) step(1'b0, 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule